// File: doc/BRIEF.md
# Masked Vector Negated-FMA Operand Router

This block sits between instruction issue and a bank of 32-bit floating-point lanes that each compute `-(a*b)+c`. On issue it takes the current destination vector, two source vectors and the operation controls. It routes each lane's `a`, `b` and `c` operands according to one of three operand orders. It can replicate the low element of the third source into every lane, and it selects the rounding mode that the lanes apply. The lane arithmetic lives outside the block and returns results after a fixed latency of `LAT` cycles.

While the lanes work, the block carries the old destination and the per-lane write and zero decisions alongside them. When the results return, it builds the final destination in a single registered merge step. Each lane takes one of four values: the lane result, the old destination element (merge masking), zero (zero masking), or zero because the lane lies beyond the selected vector length. The exception flags of the lanes that wrote a result are ORed into one status word. A new operation can be issued on every cycle.

Top module: `vec_fnma_router`

## Requirements
- R1: Operand order is selected by `form_i`. With 0, a=dest, b=src3 and c=src2. With 1, a=src2, b=dest and c=src3. With 2 or 3, a=src2, b=src3 and c=dest. Lane j uses the 32-bit element at bits [32j+31:32j].
- R2: `vlen_i` selects the number of active lanes: 0 selects LANES/4, 1 selects LANES/2, and 2 or 3 selects all LANES. Every `dest_o` bit at or above the active length is 0.
- R3: When `bflag_i`=1 and `src3_reg_i`=0, the src3 operand of every lane is `src3_i[31:0]`. Otherwise lane j takes src3 element j.
- R4: With `mask_en_i`=1, an active lane whose `mask_i` bit is 1 receives its lane result. Otherwise it keeps the old destination element when `zero_i`=0, or becomes 0 when `zero_i`=1.
- R5: With `mask_en_i`=0, every active lane receives its lane result, and `mask_i` and `zero_i` have no effect.
- R6: `lane_rm_o` equals `emb_rm_i` when `vlen_i`>=2, `bflag_i`=1 and `src3_reg_i`=1. In every other case it equals `glob_rm_i`. Setting `bflag_i` with a register third source does not replicate.
- R7: `mask_i` bits of lanes at or above the active count have no effect on `dest_o`.
- R8: `flags_o` is the OR of the 5-bit `lane_flags_i` fields (lane j at bits [5j+4:5j]) of the lanes that receive their result. `flags_o` is 0 in every cycle in which `done_o` is 0.
- R9: An issue sampled at clock edge k raises `done_o` for exactly one cycle after edge k+LAT, with the new `dest_o`. `dest_o` holds its value until the next completion. Issues on consecutive cycles complete on consecutive cycles, in order.
- R10: The old destination used by merge masking is the `dest_i` value at issue. Changes to `dest_i` after issue have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| issue_i | input | 1 | Start an operation this cycle |
| form_i | input | 2 | Operand-order select |
| vlen_i | input | 2 | Vector-length select |
| bflag_i | input | 1 | Replicate (memory source) or rounding override (register source) |
| src3_reg_i | input | 1 | Third source is a register |
| mask_en_i | input | 1 | Write masking enabled |
| zero_i | input | 1 | 1 = zero masked lanes, 0 = merge |
| mask_i | input | LANES | Per-lane write mask |
| glob_rm_i | input | 2 | Global rounding mode |
| emb_rm_i | input | 2 | Embedded rounding override |
| dest_i | input | LANES*EW | Current destination vector |
| src2_i | input | LANES*EW | Second source vector |
| src3_i | input | LANES*EW | Third source vector |
| lane_a_o | output | LANES*EW | Lane multiplicand a |
| lane_b_o | output | LANES*EW | Lane multiplicand b |
| lane_c_o | output | LANES*EW | Lane addend c |
| lane_rm_o | output | 2 | Rounding mode for the lanes |
| lane_go_o | output | 1 | Operands valid for the lanes |
| lane_res_i | input | LANES*EW | Lane results, LAT cycles after issue |
| lane_flags_i | input | LANES*5 | Lane exception flags, aligned with results |
| done_o | output | 1 | Final destination valid |
| dest_o | output | LANES*EW | Final destination vector |
| flags_o | output | 5 | ORed flags of writing lanes |

## Verification
The assertions check the combinational operand routing on every cycle: the destination reaches the correct slot for each order, and replication or pass-through of the third source. They also check the rounding-mode choice, the completion timing measured against an issue history, and that flags stay quiet outside completions. Only the bench scenarios can show the merged result. That covers the interaction of mask, zeroing and vector length, which mask bits beyond the length are ignored, capture of the old destination while `dest_i` changes, and the flag OR restricted to writing lanes. The bench does this by comparing `dest_o` and `flags_o` with a lane model and an independent reference.

// File: rtl/fnr_pkg.sv
package fnr_pkg;
  typedef enum logic [1:0] {
    FORM_DS3  = 2'd0,  // a=dest b=src3 c=src2
    FORM_S2D  = 2'd1,  // a=src2 b=dest c=src3
    FORM_S2S3 = 2'd2,  // a=src2 b=src3 c=dest
    FORM_ALT  = 2'd3   // same as FORM_S2S3
  } form_e;

  typedef enum logic [1:0] {
    VL_QTR  = 2'd0,
    VL_HALF = 2'd1,
    VL_FULL = 2'd2,
    VL_ALT  = 2'd3
  } vlen_e;

  typedef logic [1:0] rmode_t;
endpackage

// File: rtl/fnr_lane_ctl.sv
module fnr_lane_ctl #(
  parameter int LANES = 16
) (
  input  logic [1:0]       vlen_i,
  input  logic             mask_en_i,
  input  logic             zero_i,
  input  logic [LANES-1:0] mask_i,
  output logic [LANES-1:0] wr_o,
  output logic [LANES-1:0] zr_o
);
  import fnr_pkg::*;

  localparam int QtrLanes  = LANES / 4;
  localparam int HalfLanes = LANES / 2;

  int n_act;

  always_comb begin
    unique case (vlen_e'(vlen_i))
      VL_QTR:  n_act = QtrLanes;
      VL_HALF: n_act = HalfLanes;
      default: n_act = LANES;
    endcase
  end

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    logic act;
    assign act     = (j < n_act);
    assign wr_o[j] = act & (~mask_en_i | mask_i[j]);
    // inactive lanes always clear, masked lanes clear only in zeroing mode
    assign zr_o[j] = ~act | (mask_en_i & ~mask_i[j] & zero_i);
  end
endmodule

// File: rtl/fnr_opnd_mux.sv
module fnr_opnd_mux #(
  parameter int LANES = 16,
  parameter int EW    = 32
) (
  input  logic [1:0]          form_i,
  input  logic                rep_i,
  input  logic [LANES*EW-1:0] dest_i,
  input  logic [LANES*EW-1:0] src2_i,
  input  logic [LANES*EW-1:0] src3_i,
  output logic [LANES*EW-1:0] a_o,
  output logic [LANES*EW-1:0] b_o,
  output logic [LANES*EW-1:0] c_o
);
  import fnr_pkg::*;

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    logic [EW-1:0] d_e, s2_e, s3_e;
    assign d_e  = dest_i[j*EW +: EW];
    assign s2_e = src2_i[j*EW +: EW];
    assign s3_e = rep_i ? src3_i[EW-1:0] : src3_i[j*EW +: EW];

    always_comb begin
      unique case (form_e'(form_i))
        FORM_DS3: begin
          a_o[j*EW +: EW] = d_e;
          b_o[j*EW +: EW] = s3_e;
          c_o[j*EW +: EW] = s2_e;
        end
        FORM_S2D: begin
          a_o[j*EW +: EW] = s2_e;
          b_o[j*EW +: EW] = d_e;
          c_o[j*EW +: EW] = s3_e;
        end
        default: begin
          a_o[j*EW +: EW] = s2_e;
          b_o[j*EW +: EW] = s3_e;
          c_o[j*EW +: EW] = d_e;
        end
      endcase
    end
  end
endmodule

// File: rtl/fnr_ctx_pipe.sv
module fnr_ctx_pipe #(
  parameter int LANES = 16,
  parameter int EW    = 32,
  parameter int LAT   = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                vld_i,
  input  logic [LANES-1:0]    wr_i,
  input  logic [LANES-1:0]    zr_i,
  input  logic [LANES*EW-1:0] dest_i,
  output logic                vld_o,
  output logic [LANES-1:0]    wr_o,
  output logic [LANES-1:0]    zr_o,
  output logic [LANES*EW-1:0] dest_o
);
  logic [LAT-1:0]      vld_q;
  logic [LANES-1:0]    wr_q   [LAT];
  logic [LANES-1:0]    zr_q   [LAT];
  logic [LANES*EW-1:0] dest_q [LAT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= '0;
      for (int s = 0; s < LAT; s++) begin
        wr_q[s]   <= '0;
        zr_q[s]   <= '0;
        dest_q[s] <= '0;
      end
    end else begin
      vld_q     <= {vld_q[LAT-2:0], vld_i};
      wr_q[0]   <= wr_i;
      zr_q[0]   <= zr_i;
      dest_q[0] <= dest_i;
      for (int s = 1; s < LAT; s++) begin
        wr_q[s]   <= wr_q[s-1];
        zr_q[s]   <= zr_q[s-1];
        dest_q[s] <= dest_q[s-1];
      end
    end
  end

  assign vld_o  = vld_q[LAT-1];
  assign wr_o   = wr_q[LAT-1];
  assign zr_o   = zr_q[LAT-1];
  assign dest_o = dest_q[LAT-1];
endmodule

// File: rtl/fnr_merge.sv
module fnr_merge #(
  parameter int LANES = 16,
  parameter int EW    = 32,
  parameter int NF    = 5
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                vld_i,
  input  logic [LANES-1:0]    wr_i,
  input  logic [LANES-1:0]    zr_i,
  input  logic [LANES*EW-1:0] old_i,
  input  logic [LANES*EW-1:0] res_i,
  input  logic [LANES*NF-1:0] flg_i,
  output logic                done_o,
  output logic [LANES*EW-1:0] dest_o,
  output logic [NF-1:0]       flags_o
);
  logic [LANES*EW-1:0] nxt;
  logic [LANES*NF-1:0] flg_gated;
  logic [NF-1:0]       flg_or;

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    assign nxt[j*EW +: EW] = wr_i[j] ? res_i[j*EW +: EW] :
                             zr_i[j] ? '0 : old_i[j*EW +: EW];
    assign flg_gated[j*NF +: NF] = wr_i[j] ? flg_i[j*NF +: NF] : '0;
  end

  always_comb begin
    flg_or = '0;
    for (int j = 0; j < LANES; j++) flg_or |= flg_gated[j*NF +: NF];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o  <= 1'b0;
      dest_o  <= '0;
      flags_o <= '0;
    end else begin
      done_o  <= vld_i;
      flags_o <= vld_i ? flg_or : '0;
      if (vld_i) dest_o <= nxt;
    end
  end
endmodule

// File: rtl/vec_fnma_router.sv
module vec_fnma_router #(
  parameter int LANES = 16,
  parameter int EW    = 32,
  parameter int LAT   = 4,
  parameter int NF    = 5
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                issue_i,
  input  logic [1:0]          form_i,
  input  logic [1:0]          vlen_i,
  input  logic                bflag_i,
  input  logic                src3_reg_i,
  input  logic                mask_en_i,
  input  logic                zero_i,
  input  logic [LANES-1:0]    mask_i,
  input  logic [1:0]          glob_rm_i,
  input  logic [1:0]          emb_rm_i,
  input  logic [LANES*EW-1:0] dest_i,
  input  logic [LANES*EW-1:0] src2_i,
  input  logic [LANES*EW-1:0] src3_i,
  output logic [LANES*EW-1:0] lane_a_o,
  output logic [LANES*EW-1:0] lane_b_o,
  output logic [LANES*EW-1:0] lane_c_o,
  output logic [1:0]          lane_rm_o,
  output logic                lane_go_o,
  input  logic [LANES*EW-1:0] lane_res_i,
  input  logic [LANES*NF-1:0] lane_flags_i,
  output logic                done_o,
  output logic [LANES*EW-1:0] dest_o,
  output logic [NF-1:0]       flags_o
);
  import fnr_pkg::*;

  localparam int VW = LANES * EW;

  logic   rep, full_len, rm_ovr;
  rmode_t rm_sel;

  // bflag means replicate for a memory source, rounding override for a register source
  assign rep      = bflag_i & ~src3_reg_i;
  assign full_len = vlen_i[1];
  assign rm_ovr   = full_len & bflag_i & src3_reg_i;
  assign rm_sel   = rm_ovr ? rmode_t'(emb_rm_i) : rmode_t'(glob_rm_i);

  assign lane_rm_o = rm_sel;
  assign lane_go_o = issue_i;

  fnr_opnd_mux #(.LANES(LANES), .EW(EW)) i_opnd_mux (
    .form_i (form_i),
    .rep_i  (rep),
    .dest_i (dest_i),
    .src2_i (src2_i),
    .src3_i (src3_i),
    .a_o    (lane_a_o),
    .b_o    (lane_b_o),
    .c_o    (lane_c_o)
  );

  logic [LANES-1:0] wr_is, zr_is;

  fnr_lane_ctl #(.LANES(LANES)) i_lane_ctl (
    .vlen_i    (vlen_i),
    .mask_en_i (mask_en_i),
    .zero_i    (zero_i),
    .mask_i    (mask_i),
    .wr_o      (wr_is),
    .zr_o      (zr_is)
  );

  logic             vld_p;
  logic [LANES-1:0] wr_p, zr_p;
  logic [VW-1:0]    old_p;

  fnr_ctx_pipe #(.LANES(LANES), .EW(EW), .LAT(LAT)) i_ctx_pipe (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .vld_i  (issue_i),
    .wr_i   (wr_is),
    .zr_i   (zr_is),
    .dest_i (dest_i),
    .vld_o  (vld_p),
    .wr_o   (wr_p),
    .zr_o   (zr_p),
    .dest_o (old_p)
  );

  fnr_merge #(.LANES(LANES), .EW(EW), .NF(NF)) i_merge (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .vld_i   (vld_p),
    .wr_i    (wr_p),
    .zr_i    (zr_p),
    .old_i   (old_p),
    .res_i   (lane_res_i),
    .flg_i   (lane_flags_i),
    .done_o  (done_o),
    .dest_o  (dest_o),
    .flags_o (flags_o)
  );
endmodule

// File: rtl/fnr_chk.sv
module fnr_chk #(
  parameter int LANES = 16,
  parameter int EW    = 32,
  parameter int LAT   = 4,
  parameter int NF    = 5
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                issue_i,
  input logic [1:0]          form_i,
  input logic [1:0]          vlen_i,
  input logic                bflag_i,
  input logic                src3_reg_i,
  input logic [1:0]          glob_rm_i,
  input logic [1:0]          emb_rm_i,
  input logic [LANES*EW-1:0] dest_i,
  input logic [LANES*EW-1:0] src3_i,
  input logic [LANES*EW-1:0] lane_a_o,
  input logic [LANES*EW-1:0] lane_b_o,
  input logic [LANES*EW-1:0] lane_c_o,
  input logic [1:0]          lane_rm_o,
  input logic                done_o,
  input logic [NF-1:0]       flags_o
);
  logic [LAT:0] hist_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hist_q <= '0;
    else         hist_q <= {hist_q[LAT-1:0], issue_i};
  end

  // R1
  dest_in_a_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (form_i == 2'd0) |-> (lane_a_o == dest_i));
  // R1
  dest_in_b_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (form_i == 2'd1) |-> (lane_b_o == dest_i));
  // R1
  dest_in_c_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    form_i[1] |-> (lane_c_o == dest_i));
  // R3
  src3_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(bflag_i && !src3_reg_i) && form_i != 2'd1) |-> (lane_b_o == src3_i));

  for (genvar j = 0; j < LANES; j++) begin : g_rep
    // R3
    rep_b_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (bflag_i && !src3_reg_i && form_i != 2'd1)
        |-> (lane_b_o[j*EW +: EW] == src3_i[EW-1:0]));
    // R3
    rep_c_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (bflag_i && !src3_reg_i && form_i == 2'd1)
        |-> (lane_c_o[j*EW +: EW] == src3_i[EW-1:0]));
  end

  // R6
  rm_override_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vlen_i >= 2'd2 && bflag_i && src3_reg_i) |-> (lane_rm_o == emb_rm_i));
  // R6
  rm_global_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(vlen_i >= 2'd2 && bflag_i && src3_reg_i) |-> (lane_rm_o == glob_rm_i));
  // R9
  done_timing_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o == hist_q[LAT]);
  // R8
  flags_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> (flags_o == '0));
endmodule

bind vec_fnma_router fnr_chk #(.LANES(LANES), .EW(EW), .LAT(LAT), .NF(NF)) i_fnr_chk (.*);

// File: tb/test_vec_fnma_router.sv
`timescale 1ns/1ps
module test_vec_fnma_router;
  localparam int LANES = 16;
  localparam int EW    = 32;
  localparam int LAT   = 4;
  localparam int NF    = 5;
  localparam int VW    = LANES * EW;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             issue = 1'b0;
  logic [1:0]       form = '0, vlen = '0, grm = '0, erm = '0;
  logic             bflag = 1'b0, s3reg = 1'b0, men = 1'b0, zer = 1'b0;
  logic [LANES-1:0] mask = '0;
  logic [VW-1:0]    dest = '0, src2 = '0, src3 = '0;
  logic [VW-1:0]    la, lb, lc, dest_o;
  logic [1:0]       lrm;
  logic             lgo, done;
  logic [NF-1:0]    flags;
  logic [VW-1:0]       lres_q [LAT];
  logic [LANES*NF-1:0] lflg_q [LAT];

  int n_chk = 0;
  int n_err = 0;

  always #2.5 clk = ~clk;

  vec_fnma_router #(.LANES(LANES), .EW(EW), .LAT(LAT), .NF(NF)) i_vec_fnma_router (
    .clk_i(clk), .rst_ni(rst_n), .issue_i(issue), .form_i(form), .vlen_i(vlen),
    .bflag_i(bflag), .src3_reg_i(s3reg), .mask_en_i(men), .zero_i(zer), .mask_i(mask),
    .glob_rm_i(grm), .emb_rm_i(erm), .dest_i(dest), .src2_i(src2), .src3_i(src3),
    .lane_a_o(la), .lane_b_o(lb), .lane_c_o(lc), .lane_rm_o(lrm), .lane_go_o(lgo),
    .lane_res_i(lres_q[LAT-1]), .lane_flags_i(lflg_q[LAT-1]),
    .done_o(done), .dest_o(dest_o), .flags_o(flags)
  );

  // lane model: r = a + 3b + 7c, flags = c[4:0], fixed latency LAT
  function automatic logic [EW-1:0] lane_fn(logic [EW-1:0] a, logic [EW-1:0] b, logic [EW-1:0] c);
    return a + 32'd3 * b + 32'd7 * c;
  endfunction

  always @(posedge clk) begin
    for (int s = LAT - 1; s > 0; s--) begin
      lres_q[s] <= lres_q[s-1];
      lflg_q[s] <= lflg_q[s-1];
    end
    for (int j = 0; j < LANES; j++) begin
      lres_q[0][j*EW +: EW] <= lane_fn(la[j*EW +: EW], lb[j*EW +: EW], lc[j*EW +: EW]);
      lflg_q[0][j*NF +: NF] <= lc[j*EW +: NF];
    end
  end

  task automatic chk(string req, logic [VW-1:0] act, logic [VW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [VW-1:0] mkvec(int seed, int salt);
    logic [VW-1:0] v;
    for (int j = 0; j < LANES; j++)
      v[j*EW +: EW] = (32'(seed) * 32'h9E37_79B1) ^ (32'(j + salt) * 32'h85EB_CA6B) ^ 32'(j * 977 + salt);
    return v;
  endfunction

  task automatic calc(input logic [1:0] f, input logic [1:0] vl, input logic bf, input logic rg,
                      input logic me, input logic zr, input logic [LANES-1:0] mk,
                      input logic [VW-1:0] d, input logic [VW-1:0] s2, input logic [VW-1:0] s3,
                      output logic [VW-1:0] rd, output logic [NF-1:0] rf);
    int n = (vl == 2'd0) ? LANES / 4 : (vl == 2'd1) ? LANES / 2 : LANES;
    rd = '0;
    rf = '0;
    for (int j = 0; j < LANES; j++) begin
      logic [EW-1:0] e3, a, b, c;
      e3 = (bf && !rg) ? s3[EW-1:0] : s3[j*EW +: EW];
      if (f == 2'd0)      begin a = d[j*EW +: EW];  b = e3;             c = s2[j*EW +: EW]; end
      else if (f == 2'd1) begin a = s2[j*EW +: EW]; b = d[j*EW +: EW];  c = e3;             end
      else                begin a = s2[j*EW +: EW]; b = e3;             c = d[j*EW +: EW];  end
      if (j < n) begin
        if (!me || mk[j]) begin
          rd[j*EW +: EW] = lane_fn(a, b, c);
          rf |= c[NF-1:0];
        end else if (!zr) begin
          rd[j*EW +: EW] = d[j*EW +: EW];
        end
      end
    end
  endtask

  task automatic drive(logic [1:0] f, logic [1:0] vl, logic bf, logic rg, logic me, logic zr,
                       logic [LANES-1:0] mk, logic [1:0] g, logic [1:0] e, int seed);
    form = f; vlen = vl; bflag = bf; s3reg = rg; men = me; zer = zr; mask = mk;
    grm = g; erm = e;
    dest = mkvec(seed, 1); src2 = mkvec(seed, 2); src3 = mkvec(seed, 3);
    issue = 1'b1;
  endtask

  task automatic do_op(string req, logic [1:0] f, logic [1:0] vl, logic bf, logic rg,
                       logic me, logic zr, logic [LANES-1:0] mk, logic [1:0] g, logic [1:0] e,
                       int seed);
    logic [VW-1:0] xd;
    logic [NF-1:0] xf;
    logic [1:0]    xrm;
    int            cnt;
    @(negedge clk);
    drive(f, vl, bf, rg, me, zr, mk, g, e, seed);
    calc(f, vl, bf, rg, me, zr, mk, dest, src2, src3, xd, xf);
    xrm = (vl >= 2'd2 && bf && rg) ? e : g;
    #1;
    chk("R6 lane rounding mode", VW'(lrm), VW'(xrm));
    @(negedge clk);
    issue = 1'b0;
    dest  = ~dest;  // R10: post-issue change must not reach the result
    cnt = 1;
    while (!done && cnt < 20) begin
      @(negedge clk);
      cnt++;
    end
    chk("R9 completion latency", VW'(cnt), VW'(LAT + 1));
    chk(req, dest_o, xd);
    chk("R8 flags of writing lanes", VW'(flags), VW'(xf));
  endtask

  task automatic t_reset();
    chk("R9 reset done", VW'(done), '0);
    chk("R2 reset dest", dest_o, '0);
    chk("R8 reset flags", VW'(flags), '0);
  endtask

  task automatic t_forms();
    for (int f = 0; f < 4; f++)
      do_op("R1 operand order", 2'(f), 2'd2, 1'b0, 1'b1, 1'b0, 1'b0, '0, 2'd1, 2'd3, 10 + f);
  endtask

  task automatic t_vlen();
    do_op("R2 quarter length upper zero", 2'd0, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, '0, 2'd0, 2'd1, 20);
    do_op("R2 half length upper zero", 2'd2, 2'd1, 1'b0, 1'b1, 1'b0, 1'b0, '0, 2'd0, 2'd1, 21);
    do_op("R2 full length alt code", 2'd1, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, '0, 2'd2, 2'd1, 22);
  endtask

  task automatic t_bcast();
    do_op("R3 replicate into b", 2'd0, 2'd1, 1'b1, 1'b0, 1'b0, 1'b0, '0, 2'd2, 2'd3, 30);
    do_op("R3 replicate into c", 2'd1, 2'd2, 1'b1, 1'b0, 1'b0, 1'b0, '0, 2'd2, 2'd3, 31);
  endtask

  task automatic t_round();
    do_op("R6 override at full length, no replicate", 2'd2, 2'd2, 1'b1, 1'b1, 1'b0, 1'b0, '0, 2'd0, 2'd3, 40);
    do_op("R6 no override at half length", 2'd0, 2'd1, 1'b1, 1'b1, 1'b0, 1'b0, '0, 2'd1, 2'd2, 41);
  endtask

  task automatic t_mask();
    do_op("R4 R10 merge masking", 2'd0, 2'd2, 1'b0, 1'b1, 1'b1, 1'b0, 16'hA5C3, 2'd0, 2'd0, 50);
    do_op("R4 zero masking", 2'd2, 2'd2, 1'b0, 1'b1, 1'b1, 1'b1, 16'h3C96, 2'd0, 2'd0, 51);
    do_op("R5 mask and zero ignored when disabled", 2'd1, 2'd1, 1'b0, 1'b1, 1'b0, 1'b1, 16'h0000, 2'd0, 2'd0, 52);
    do_op("R7 mask above length ignored", 2'd0, 2'd0, 1'b0, 1'b1, 1'b1, 1'b0, 16'hFFF5, 2'd0, 2'd0, 53);
    do_op("R7 all-zero mask merges, upper zero", 2'd2, 2'd1, 1'b0, 1'b1, 1'b1, 1'b0, 16'hFF00, 2'd0, 2'd0, 54);
  endtask

  task automatic t_back2back();
    logic [VW-1:0] xa, xb;
    logic [NF-1:0] fa, fb;
    @(negedge clk);
    drive(2'd0, 2'd2, 1'b0, 1'b1, 1'b1, 1'b0, 16'h0F0F, 2'd0, 2'd0, 60);
    calc(2'd0, 2'd2, 1'b0, 1'b1, 1'b1, 1'b0, 16'h0F0F, dest, src2, src3, xa, fa);
    @(negedge clk);
    drive(2'd1, 2'd1, 1'b0, 1'b1, 1'b1, 1'b1, 16'h00F3, 2'd0, 2'd0, 61);
    calc(2'd1, 2'd1, 1'b0, 1'b1, 1'b1, 1'b1, 16'h00F3, dest, src2, src3, xb, fb);
    @(negedge clk);
    issue = 1'b0;
    repeat (LAT - 1) @(negedge clk);
    chk("R9 first of pair done", VW'(done), VW'(1));
    chk("R9 first of pair data", dest_o, xa);
    @(negedge clk);
    chk("R9 second of pair done", VW'(done), VW'(1));
    chk("R9 second of pair data", dest_o, xb);
    chk("R8 second of pair flags", VW'(flags), VW'(fb));
    @(negedge clk);
    chk("R9 done is a pulse", VW'(done), '0);
    chk("R9 dest holds", dest_o, xb);
    chk("R8 flags clear when idle", VW'(flags), '0);
  endtask

  initial begin
    #(200000 * 5);
    n_chk++;
    n_err++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_forms();
    t_vlen();
    t_bcast();
    t_round();
    t_mask();
    t_back2back();
    repeat (3) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule